// File: doc/BRIEF.md
# Ten-Port Open-Drain GPIO Register File

This block holds the control state of ten open-drain I/O ports and answers register reads for them. Each command arrives as one already-assembled word: a read/write flag, a 7-bit register address and a data byte, presented with a valid/ready handshake. A write updates one port register, a group of port registers, or a spare scratch byte. A read returns one byte on a response channel in the cycle after the command is accepted.

Each port has an 8-bit level register. Only bit 0 of that register decides the pad: 0 pulls the pin low, and 1 releases it so it can float high or be used as an input. The raw pin levels are passed through a two-flop synchronizer and can be read back as two bytes. A few addresses write the same byte into several port registers at once. Reading one of those addresses returns the first port of its group.

The command channel never applies back-pressure: `cmd_ready` is always 1, and every cycle with `cmd_valid` high is one accepted command. The response channel has no ready signal. A consumer must take `rsp_data` in the cycle where `rsp_valid` is high, because the next read overwrites it.

Top module: `odio_regfile`

## Requirements
- R1: While reset is held, and after it is released, every port register holds 0xFF, so `pull_low` is all zeros. The scratch byte at 0x13 holds 0x00 and `rsp_valid` is 0.
- R2: A write to address i, where i is in 0x00..0x09, stores all eight data bits in the register of port i. A later read of address i returns those bits unchanged.
- R3: `pull_low[i]` is 1 exactly when bit 0 of the register of port i is 0. It changes in the cycle after the write is accepted.
- R4: A write to 0x0A stores the data byte into all ten port registers.
- R5: A write to 0x0B stores into ports 0..3, a write to 0x0C into ports 4..7, and a write to 0x0D into ports 8..9. The group address is 0x0B plus the port index divided by 4, rounded down. No other port changes.
- R6: A read of 0x0A or 0x0B returns the register of port 0. A read of 0x0C returns port 4, and a read of 0x0D returns port 8.
- R7: A read of 0x0E returns synchronized pins 7..0, with pin 7 in bit 7. A read of 0x0F returns pin 9 in bit 1 and pin 8 in bit 0, with bits 7..2 zero. A pin change is visible to a read accepted two or more clock edges after the change.
- R8: Writes to 0x0E, 0x0F, 0x20, 0x7D or any other unmapped address change no port register and do not change the scratch byte.
- R9: A read of any address other than 0x00..0x0F and 0x13 returns 0x00. This includes 0x20 and 0x7D.
- R10: A write to 0x13 stores the byte, and a read of 0x13 returns it.
- R11: `cmd_ready` is always 1. `rsp_valid` is 1 in exactly the cycle after a read is accepted, and is 0 after a write or an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_ready | output | 1 | Always 1; the block never stalls |
| cmd_rw | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | 7 | Register address |
| cmd_data | input | 8 | Write data byte (ignored on reads) |
| pin_in | input | 10 | Raw pin levels, asynchronous |
| pull_low | output | 10 | Per-port pull-down enable |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_data | output | 8 | Read data byte |

## Verification
Writes take effect at the accepting edge. The bench therefore drives a command on a falling edge and checks `pull_low` on the next falling edge. Read data is registered, so `rsp_valid` and `rsp_data` are checked one falling edge after the read is driven. A pin change needs two synchronizer edges before a read can see it. The bench changes the pins and then waits three full cycles before issuing a read of 0x0E or 0x0F. The expected value of every address, across a sweep of all 128, is computed from a model of the register contents that the bench keeps.

// File: rtl/odio_pkg.sv
package odio_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] A_ALL  = 7'h0A;
  localparam logic [ADDR_W-1:0] A_GRP0 = 7'h0B;
  localparam logic [ADDR_W-1:0] A_PIN0 = 7'h0E;
  localparam logic [ADDR_W-1:0] A_RAM  = 7'h13;
  localparam logic [ADDR_W-1:0] A_NOP  = 7'h20;
  localparam logic [ADDR_W-1:0] A_RSV  = 7'h7D;
endpackage

// File: rtl/odio_sync.sv
module odio_sync #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

  // R7: the second stage lags the first by exactly one edge
  assert_sync_stage_R7: assert property (@(posedge clk) disable iff (!rst_n)
    q == $past(stage1));
endmodule

// File: rtl/odio_port_bank.sv
module odio_port_bank
  import odio_pkg::*;
#(
  parameter int NPORT = 10,
  parameter int GRP   = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [NPORT-1:0][DATA_W-1:0]  q
);
  logic [NPORT-1:0] hit;

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    localparam int G = i / GRP;
    assign hit[i] = wr_en && ((wr_addr == ADDR_W'(i)) || (wr_addr == A_ALL) ||
                              (wr_addr == A_GRP0 + ADDR_W'(G)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= '1;
      else if (hit[i]) q[i] <= wr_data;
    end

    // R2/R4/R5: a selected port stores the full byte
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> q[i] == $past(wr_data));
  end
endmodule

// File: rtl/odio_read_mux.sv
module odio_read_mux
  import odio_pkg::*;
#(
  parameter int NPORT = 10,
  parameter int GRP   = 4
) (
  input  logic [ADDR_W-1:0]            addr,
  input  logic [NPORT-1:0][DATA_W-1:0] ports,
  input  logic [DATA_W-1:0]            ram,
  input  logic [NPORT-1:0]             pins,
  output logic [DATA_W-1:0]            rd
);
  localparam int NGRP  = (NPORT + GRP - 1) / GRP;
  localparam int NPAGE = (NPORT + 7) / 8;
  localparam int PW    = NPAGE * 8;

  logic [PW-1:0] pad;
  assign pad = PW'(pins);

  always_comb begin
    rd = '0;
    for (int i = 0; i < NPORT; i++)
      if (addr == ADDR_W'(i)) rd = ports[i];
    if (addr == A_ALL) rd = ports[0];
    for (int g = 0; g < NGRP; g++)
      if (addr == A_GRP0 + ADDR_W'(g)) rd = ports[g*GRP];
    for (int p = 0; p < NPAGE; p++)
      if (addr == A_PIN0 + ADDR_W'(p)) rd = pad[p*8 +: 8];
    if (addr == A_RAM) rd = ram;
  end
endmodule

// File: rtl/odio_regfile.sv
module odio_regfile
  import odio_pkg::*;
#(
  parameter int NPORT = 10,
  parameter int GRP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_rw,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [NPORT-1:0]  pin_in,
  output logic [NPORT-1:0]  pull_low,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  logic                           wr_en, rd_en;
  logic [NPORT-1:0][DATA_W-1:0]   port_q;
  logic [DATA_W-1:0]              ram_q, mux_rd;
  logic [NPORT-1:0]               pin_sync;

  assign cmd_ready = 1'b1;
  assign wr_en = cmd_valid && !cmd_rw;
  assign rd_en = cmd_valid && cmd_rw;

  odio_sync #(.W(NPORT)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync));

  odio_port_bank #(.NPORT(NPORT), .GRP(GRP)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(cmd_addr),
    .wr_data(cmd_data), .q(port_q));

  odio_read_mux #(.NPORT(NPORT), .GRP(GRP)) u_mux (
    .addr(cmd_addr), .ports(port_q), .ram(ram_q), .pins(pin_sync), .rd(mux_rd));

  for (genvar i = 0; i < NPORT; i++) begin : g_pad
    assign pull_low[i] = ~port_q[i][0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ram_q <= '0;
    else if (wr_en && cmd_addr == A_RAM) ram_q <= cmd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) rsp_data <= mux_rd;
    end
  end

  // R1: reset leaves every port released and no response pending
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (pull_low == '0 && rsp_valid == 1'b0 && ram_q == '0));

  // R11: a response appears only after an accepted read
  assert_rsp_follows_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(cmd_valid && cmd_rw));

  // R8: writes to read-only, no-op and reserved addresses leave state alone
  assert_ignored_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (cmd_addr == A_PIN0 || cmd_addr == A_PIN0 + 7'd1 ||
               cmd_addr == A_NOP || cmd_addr == A_RSV))
    |=> ($stable(pull_low) && $stable(ram_q)));

  // R10: scratch byte captures its write
  assert_ram_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cmd_addr == A_RAM) |=> ram_q == $past(cmd_data));

  // R9: the no-op address reads as zero
  assert_nop_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && cmd_addr == A_NOP) |=> rsp_data == '0);
endmodule

// File: tb/odio_regfile_tb.sv
module odio_regfile_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic       cmd_rw = 1'b0;
  logic [6:0] cmd_addr = '0;
  logic [7:0] cmd_data = '0;
  logic [9:0] pin_in = '0;
  logic [9:0] pull_low;
  logic       rsp_valid;
  logic [7:0] rsp_data;

  int total = 0;
  int bad = 0;
  logic [7:0] m_port [10];
  logic [7:0] m_ram;
  logic [9:0] m_pins;

  always #4 clk = ~clk;

  odio_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_rw(cmd_rw), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .pin_in(pin_in), .pull_low(pull_low), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] exp_pull();
    logic [9:0] v;
    for (int i = 0; i < 10; i++) v[i] = ~m_port[i][0];
    return v;
  endfunction

  function automatic logic [7:0] exp_read(input logic [6:0] a);
    if (a < 7'd10) return m_port[a];
    case (a)
      7'h0A, 7'h0B: return m_port[0];
      7'h0C:        return m_port[4];
      7'h0D:        return m_port[8];
      7'h0E:        return m_pins[7:0];
      7'h0F:        return {6'b0, m_pins[9:8]};
      7'h13:        return m_ram;
      default:      return 8'h00;
    endcase
  endfunction

  task automatic model_write(input logic [6:0] a, input logic [7:0] d);
    for (int i = 0; i < 10; i++)
      if (a == 7'(i) || a == 7'h0A || a == 7'h0B + 7'(i / 4)) m_port[i] = d;
    if (a == 7'h13) m_ram = d;
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d, input string req);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_rw = 1'b0; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    model_write(a, d);
    chk({req, " pull_low"}, 32'(pull_low), 32'(exp_pull()));
    chk("R11 no response after write", 32'(rsp_valid), 32'd0);
  endtask

  task automatic rd(input logic [6:0] a, input string req);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_rw = 1'b1; cmd_addr = a; cmd_data = 8'hC3;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R11 rsp_valid", 32'(rsp_valid), 32'd1);
    chk(req, 32'(rsp_data), 32'(exp_read(a)));
  endtask

  task automatic set_pins(input logic [9:0] p);
    @(negedge clk);
    pin_in = p;
    m_pins = p;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 10; i++) m_port[i] = 8'hFF;
    m_ram = 8'h00;
    m_pins = '0;
    repeat (3) @(negedge clk);
    chk("R1 pull_low in reset", 32'(pull_low), 32'd0);
    chk("R1 rsp_valid in reset", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 cmd_ready", 32'(cmd_ready), 32'd1);
    chk("R1 pull_low after reset", 32'(pull_low), 32'd0);
    chk("R11 idle rsp_valid", 32'(rsp_valid), 32'd0);
    for (int i = 0; i < 10; i++) rd(7'(i), "R1 port reset value");
    rd(7'h13, "R1 scratch reset value");

    // R2 / R3 direct writes with several byte patterns
    for (int i = 0; i < 10; i++) begin
      wr(7'(i), 8'h00, "R3 drive low");
      rd(7'(i), "R2 readback 00");
      wr(7'(i), 8'hA5, "R3 odd byte releases");
      rd(7'(i), "R2 readback A5");
      wr(7'(i), 8'h5A, "R3 even byte pulls");
      rd(7'(i), "R2 readback 5A");
      wr(7'(i), 8'h01, "R3 release");
    end

    // R4 broadcast and R5 groups, with R6 alias reads
    wr(7'h0A, 8'h00, "R4 broadcast low");
    for (int i = 0; i < 10; i++) rd(7'(i), "R4 broadcast readback");
    wr(7'h0B, 8'h37, "R5 group 0");
    wr(7'h0C, 8'h42, "R5 group 1");
    wr(7'h0D, 8'h99, "R5 group 2");
    for (int i = 0; i < 10; i++) rd(7'(i), "R5 group readback");
    for (int a = 10; a < 14; a++) rd(7'(a), "R6 alias read");
    wr(7'h0C, 8'hFE, "R5 group 1 again");
    rd(7'h0C, "R6 alias read group 1");
    rd(7'h0A, "R6 alias read all");

    // R10 scratch byte
    wr(7'h13, 8'h6D, "R10 scratch write");
    rd(7'h13, "R10 scratch readback");
    wr(7'h13, 8'hFF, "R10 scratch rewrite");
    rd(7'h13, "R10 scratch readback 2");

    // R7 pin reads: walking one plus dense patterns
    for (int b = 0; b < 10; b++) begin
      set_pins(10'(1) << b);
      rd(7'h0E, "R7 low pins");
      rd(7'h0F, "R7 high pins");
    end
    set_pins(10'h3FF); rd(7'h0E, "R7 all ones low"); rd(7'h0F, "R7 all ones high");
    set_pins(10'h2AA); rd(7'h0E, "R7 pattern low"); rd(7'h0F, "R7 pattern high");

    // R8 ignored writes: state must read back unchanged
    for (int i = 0; i < 10; i++) wr(7'(i), 8'(i * 37 + 4), "R2 distinct load");
    wr(7'h0E, 8'h00, "R8 write to pin page 0");
    wr(7'h0F, 8'h00, "R8 write to pin page 1");
    wr(7'h20, 8'h00, "R8 write to no-op");
    wr(7'h7D, 8'h00, "R8 write to reserved");
    wr(7'h10, 8'h00, "R8 write unmapped 10");
    wr(7'h7F, 8'h00, "R8 write unmapped 7F");
    for (int i = 0; i < 10; i++) rd(7'(i), "R8 ports unchanged");
    rd(7'h13, "R8 scratch unchanged");
    rd(7'h0E, "R8 pin page unchanged");

    // R9 full address sweep against the model
    for (int a = 0; a < 128; a++) rd(7'(a), "R9 address sweep");

    @(negedge clk);
    chk("R11 rsp_valid drops", 32'(rsp_valid), 32'd0);
    finish_run();
  end
endmodule